// File: doc/BRIEF.md
# Path REI error-count inserter

This block produces the four-bit path remote error indication that goes into bits 7..4 of the G1 byte. It covers up to three STS-1 channels. For each channel the receive side reports how many interleaved bit blocks the B3 parity check found in error during the frame that just completed. On every frame strobe the block captures that count, or a value from the protection board when the protection select is set, and holds it as the outgoing REI nibble until the next strobe.

Software can switch off automatic insertion for each channel. An inhibited channel sends zero. Software can still force exactly one error into an inhibited channel by pulsing a single-error trigger. A small trigger state machine latches the pulse between frames and lets exactly one frame consume it. The machine has two states. `TRG_IDLE` moves to `TRG_PENDING` on a trigger pulse that does not coincide with a strobe. `TRG_PENDING` returns to `TRG_IDLE` on the next strobe. A pulse that coincides with a strobe in `TRG_IDLE` is consumed by that strobe, and the machine stays in `TRG_IDLE`. In STM-1 mode a single path spans the three channels, so the control bit of channel 0 governs all of them.

Top module: `path_rei_inserter`

## Requirements
- R1: After reset every REI nibble of `rei_out` is 0000 and no trigger is pending.
- R2: `rei_out` changes only in the clock cycle after a cycle with `frame_strobe` high; between strobes it holds its value whatever the other inputs do.
- R3: For a channel that is not inhibited, with `prot_sel` low, the nibble at bits [4i+3:4i] of `rei_out` becomes the channel's `b3_err_cnt` nibble (same bit positions) sampled at the strobe.
- R4: Any source count above 8, local or protection, is inserted as 8 (1000).
- R5: With `prot_sel` high, a channel that is not inhibited takes its nibble from `prot_rei` (bits [4i+3:4i]) instead of `b3_err_cnt`.
- R6: An inhibited channel with no pending trigger sends 0000, whatever its count and whatever `prot_sel` is.
- R7: An inhibited channel sends 0001 in the frame captured by the first strobe at or after an `err_trig` pulse. The pulse may arrive in the same cycle as that strobe. Following frames send 0000 again.
- R8: Several `err_trig` pulses before one strobe still give exactly one frame of 0001.
- R9: With `stm1_mode` high, `auto_inhibit[0]` sets the inhibit state of every channel and `auto_inhibit[2:1]` has no effect.
- R10: A trigger has no effect on channels that are not inhibited. It is consumed by the next strobe even when no channel is inhibited at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle pulse that marks the frame boundary |
| b3_err_cnt | input | 12 | Errored B3 block count per channel, 4 bits per channel, channel i at [4i+3:4i] |
| auto_inhibit | input | 3 | Per-channel inhibit of automatic REI, 1 = inhibited |
| err_trig | input | 1 | Software single-error insert pulse |
| stm1_mode | input | 1 | 1 = one STM-1 path; channel 0 control applies to all |
| prot_sel | input | 1 | 1 = take REI from protection path |
| prot_rei | input | 12 | REI counts from the protection board, same layout as b3_err_cnt |
| rei_out | output | 12 | Outgoing REI nibble per channel, same layout |

## Verification
The assertions assume that `frame_strobe` is a single-cycle pulse. The exact-value properties for R3 and R5 assume a source count of 8 or less, and larger counts are left to the range property for R4. The stimulus drives every input on the falling clock edge and raises the strobe for exactly one cycle. Counts and selects are held steady across each strobe, and counts above 8 appear only in the clamp scenarios. Trigger pulses are one cycle long, except where several are deliberately stacked before a single strobe.

// File: rtl/rei_pkg.sv
package rei_pkg;
    typedef enum logic [0:0] {
        TRG_IDLE    = 1'b0,
        TRG_PENDING = 1'b1
    } trg_state_e;
endpackage

// File: rtl/rei_trig_fsm.sv
module rei_trig_fsm
    import rei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_trig,
    input  logic frame_strobe,
    output logic trig_hit
);
    trg_state_e state_q;
    trg_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE:    if (err_trig && !frame_strobe) state_d = TRG_PENDING;
            TRG_PENDING: if (frame_strobe)              state_d = TRG_IDLE;
            default:                                    state_d = TRG_IDLE;
        endcase
    end

    // Output: a trigger is delivered to the frame being captured
    always_comb begin
        trig_hit = 1'b0;
        unique case (state_q)
            TRG_IDLE:    trig_hit = frame_strobe && err_trig;
            TRG_PENDING: trig_hit = frame_strobe;
            default:     trig_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rei_chan_sel.sv
module rei_chan_sel #(
    parameter int REI_W   = 4,
    parameter int MAX_CNT = 8
) (
    input  logic [REI_W-1:0] local_cnt,
    input  logic [REI_W-1:0] prot_cnt,
    input  logic             prot_sel,
    input  logic             inhibit,
    input  logic             trig_hit,
    output logic [REI_W-1:0] rei_next
);
    localparam logic [REI_W-1:0] CAP = REI_W'(MAX_CNT);

    logic [REI_W-1:0] src_cnt;
    logic [REI_W-1:0] capped;

    always_comb begin
        src_cnt = prot_sel ? prot_cnt : local_cnt;
        capped  = (src_cnt > CAP) ? CAP : src_cnt;
        if (inhibit) rei_next = {{(REI_W-1){1'b0}}, trig_hit};
        else         rei_next = capped;
    end
endmodule

// File: rtl/path_rei_inserter.sv
module path_rei_inserter #(
    parameter int NUM_CH  = 3,
    parameter int REI_W   = 4,
    parameter int MAX_CNT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_strobe,
    input  logic [NUM_CH*REI_W-1:0] b3_err_cnt,
    input  logic [NUM_CH-1:0]       auto_inhibit,
    input  logic                    err_trig,
    input  logic                    stm1_mode,
    input  logic                    prot_sel,
    input  logic [NUM_CH*REI_W-1:0] prot_rei,
    output logic [NUM_CH*REI_W-1:0] rei_out
);
    logic              trig_hit;
    logic [NUM_CH-1:0] eff_inhibit;

    rei_trig_fsm u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_trig     (err_trig),
        .frame_strobe (frame_strobe),
        .trig_hit     (trig_hit)
    );

    assign eff_inhibit = stm1_mode ? {NUM_CH{auto_inhibit[0]}} : auto_inhibit;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [REI_W-1:0] rei_next;

        rei_chan_sel #(
            .REI_W   (REI_W),
            .MAX_CNT (MAX_CNT)
        ) u_sel (
            .local_cnt (b3_err_cnt[ch*REI_W +: REI_W]),
            .prot_cnt  (prot_rei[ch*REI_W +: REI_W]),
            .prot_sel  (prot_sel),
            .inhibit   (eff_inhibit[ch]),
            .trig_hit  (trig_hit),
            .rei_next  (rei_next)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            rei_out[ch*REI_W +: REI_W] <= '0;
            else if (frame_strobe) rei_out[ch*REI_W +: REI_W] <= rei_next;
        end
    end
endmodule

// File: rtl/rei_checker.sv
module rei_checker #(
    parameter int NUM_CH  = 3,
    parameter int REI_W   = 4,
    parameter int MAX_CNT = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_strobe,
    input logic [NUM_CH*REI_W-1:0] b3_err_cnt,
    input logic [NUM_CH-1:0]       auto_inhibit,
    input logic                    stm1_mode,
    input logic                    prot_sel,
    input logic [NUM_CH*REI_W-1:0] prot_rei,
    input logic [NUM_CH*REI_W-1:0] rei_out
);
    localparam logic [REI_W-1:0] CAP = REI_W'(MAX_CNT);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(rei_out));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        logic inh;
        assign inh = stm1_mode ? auto_inhibit[0] : auto_inhibit[ch];

        p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rei_out[ch*REI_W +: REI_W] <= CAP);

        p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_strobe && !inh && !prot_sel && b3_err_cnt[ch*REI_W +: REI_W] <= CAP)
            |=> rei_out[ch*REI_W +: REI_W] == $past(b3_err_cnt[ch*REI_W +: REI_W]));

        p_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_strobe && !inh && prot_sel && prot_rei[ch*REI_W +: REI_W] <= CAP)
            |=> rei_out[ch*REI_W +: REI_W] == $past(prot_rei[ch*REI_W +: REI_W]));

        p_inhib_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_strobe && inh) |=> rei_out[ch*REI_W +: REI_W] <= 1);
    end
endmodule

bind path_rei_inserter rei_checker #(
    .NUM_CH  (NUM_CH),
    .REI_W   (REI_W),
    .MAX_CNT (MAX_CNT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .b3_err_cnt   (b3_err_cnt),
    .auto_inhibit (auto_inhibit),
    .stm1_mode    (stm1_mode),
    .prot_sel     (prot_sel),
    .prot_rei     (prot_rei),
    .rei_out      (rei_out)
);

// File: tb/sim_path_rei_inserter.sv
module sim_path_rei_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [11:0] b3_err_cnt = '0;
    logic [2:0]  auto_inhibit = '0;
    logic        err_trig = 1'b0;
    logic        stm1_mode = 1'b0;
    logic        prot_sel = 1'b0;
    logic [11:0] prot_rei = '0;
    logic [11:0] rei_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    path_rei_inserter u0 (
        .clk (clk), .rst_n (rst_n), .frame_strobe (frame_strobe),
        .b3_err_cnt (b3_err_cnt), .auto_inhibit (auto_inhibit),
        .err_trig (err_trig), .stm1_mode (stm1_mode), .prot_sel (prot_sel),
        .prot_rei (prot_rei), .rei_out (rei_out)
    );

    task automatic chk(input string req, input int ch, input logic [3:0] exp);
        checks++;
        if (rei_out[ch*4 +: 4] !== exp) begin
            errors++;
            $display("FAIL %s ch%0d actual %0d expected %0d", req, ch, rei_out[ch*4 +: 4], exp);
        end
    endtask

    task automatic chk3(input string req, input logic [3:0] e0, input logic [3:0] e1, input logic [3:0] e2);
        chk(req, 0, e0);
        chk(req, 1, e1);
        chk(req, 2, e2);
    endtask

    task automatic set_b3(input logic [3:0] c0, input logic [3:0] c1, input logic [3:0] c2);
        b3_err_cnt = {c2, c1, c0};
    endtask

    // Strobe for one cycle; outputs are sampled on the falling edge after capture
    task automatic do_frame();
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk) err_trig = 1'b1;
        @(negedge clk) err_trig = 1'b0;
    endtask

    task automatic t_reset();
        chk3("R1", 4'd0, 4'd0, 4'd0);
    endtask

    task automatic t_auto_local();
        auto_inhibit = 3'b000; prot_sel = 1'b0;
        set_b3(4'd3, 4'd0, 4'd8); do_frame();
        chk3("R3", 4'd3, 4'd0, 4'd8);
        set_b3(4'd1, 4'd5, 4'd7); do_frame();
        chk3("R3", 4'd1, 4'd5, 4'd7);
    endtask

    task automatic t_hold();
        set_b3(4'd6, 4'd6, 4'd6); prot_sel = 1'b1; prot_rei = '0;
        repeat (5) @(negedge clk);
        chk3("R2", 4'd1, 4'd5, 4'd7);
        prot_sel = 1'b0; do_frame();
        chk3("R2", 4'd6, 4'd6, 4'd6);
    endtask

    task automatic t_clamp();
        set_b3(4'd9, 4'd15, 4'd12); do_frame();
        chk3("R4", 4'd8, 4'd8, 4'd8);
        prot_sel = 1'b1; prot_rei = {4'd15, 4'd2, 4'd10}; do_frame();
        chk3("R4", 4'd8, 4'd2, 4'd8);
        prot_sel = 1'b0;
    endtask

    task automatic t_prot();
        set_b3(4'd2, 4'd2, 4'd2);
        prot_sel = 1'b1; prot_rei = {4'd1, 4'd4, 4'd6}; do_frame();
        chk3("R5", 4'd6, 4'd4, 4'd1);
        prot_sel = 1'b0; do_frame();
        chk3("R5", 4'd2, 4'd2, 4'd2);
    endtask

    task automatic t_inhibit_idle();
        auto_inhibit = 3'b111; set_b3(4'd5, 4'd5, 4'd5); do_frame();
        chk3("R6", 4'd0, 4'd0, 4'd0);
        prot_sel = 1'b1; prot_rei = {4'd7, 4'd7, 4'd7}; do_frame();
        chk3("R6", 4'd0, 4'd0, 4'd0);
        prot_sel = 1'b0;
    endtask

    task automatic t_trigger_single();
        auto_inhibit = 3'b010; set_b3(4'd4, 4'd4, 4'd4);
        pulse_trig(); do_frame();
        chk3("R7", 4'd4, 4'd1, 4'd4);
        do_frame();
        chk3("R7", 4'd4, 4'd0, 4'd4);
        // trigger coinciding with the strobe
        @(negedge clk) begin frame_strobe = 1'b1; err_trig = 1'b1; end
        @(negedge clk) begin frame_strobe = 1'b0; err_trig = 1'b0; end
        chk3("R7", 4'd4, 4'd1, 4'd4);
        do_frame();
        chk3("R7", 4'd4, 4'd0, 4'd4);
    endtask

    task automatic t_multi_pulse();
        auto_inhibit = 3'b111;
        pulse_trig(); pulse_trig(); pulse_trig();
        do_frame();
        chk3("R8", 4'd1, 4'd1, 4'd1);
        do_frame();
        chk3("R8", 4'd0, 4'd0, 4'd0);
    endtask

    task automatic t_trig_consumed();
        auto_inhibit = 3'b000; set_b3(4'd3, 4'd2, 4'd1);
        pulse_trig(); do_frame();
        chk3("R10", 4'd3, 4'd2, 4'd1);
        auto_inhibit = 3'b111; do_frame();
        chk3("R10", 4'd0, 4'd0, 4'd0);
    endtask

    task automatic t_stm1();
        stm1_mode = 1'b1; auto_inhibit = 3'b110; set_b3(4'd3, 4'd6, 4'd2);
        do_frame();
        chk3("R9", 4'd3, 4'd6, 4'd2);
        auto_inhibit = 3'b001; do_frame();
        chk3("R9", 4'd0, 4'd0, 4'd0);
        stm1_mode = 1'b0; do_frame();
        chk3("R9", 4'd0, 4'd6, 4'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_local();
        t_hold();
        t_clamp();
        t_prot();
        t_inhibit_idle();
        t_trigger_single();
        t_multi_pulse();
        t_trig_consumed();
        t_stm1();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule